// File: doc/BRIEF.md
# Chip Reset Sequencer

This block sequences chip-level reset from three origins: an active-low power-on input, an open-drain hard-reset pin and an open-drain soft-reset pin. Internal hard and soft reset requests are also accepted. Each open-drain pin is modelled as two signals. A `*_drv_o` output is 1 while the block pulls the pad low. A `*_pin_i` input carries the level sensed at the pad, which an external pull-up brings back high once every driver lets go.

After power-on the block holds everything in reset until the PLL reports lock. It then releases the hard pin, the soft pin and the internal power-on reset after separate hold lengths, each counted from lock. A hard flow drives both pins for a fixed length. A soft flow drives only the soft pin, for a shorter length. After any release the block waits until both pins are sensed high, then keeps a fixed guard interval before it accepts new requests. A one-cycle strobe after power-on release marks when the mode pins are to be captured. A one-cycle strobe at the start of every hard flow marks when the hard configuration word is to be loaded.

The power-on input is the block's asynchronous reset. The environment is expected to hold it low for at least 16 clocks. The pin inputs pass through a two-stage synchronizer before the sequencer uses them.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n_i` is low, `hard_drv_o` and `soft_drv_o` are 1, `int_rst_n_o` is 0, `status_o` is 1 (power-on) and `stuck_err_o` is 0.
- R2: `cfg_sample_o` is high for exactly one cycle, the first cycle after `por_n_i` is released.
- R3: Nothing is released while `pll_locked_i` is low. Counting from the first clock edge that sees lock, the hard pin is driven for POR_HARD_CYC cycles, the soft pin for POR_SOFT_CYC cycles and `int_rst_n_o` is held low for POR_INT_CYC cycles.
- R4: In idle, a low synchronized hard pin or `hard_req_i` starts a hard flow. Both drivers are then asserted for exactly HARD_CYC cycles and released together.
- R5: `cfg_load_o` pulses for one cycle at the start of each hard flow and never during a soft flow.
- R6: In idle, a low synchronized soft pin or `soft_req_i` starts a soft flow. `soft_drv_o` is then asserted for exactly SOFT_CYC cycles, and `hard_drv_o` stays 0.
- R7: A hard request during a soft flow aborts it on the next edge and starts a full HARD_CYC hard flow.
- R8: A soft request during a hard flow has no effect on the hard flow or on the sequence that follows it.
- R9: After a release the block waits until both synchronized pins are high, then keeps a guard of GUARD_CYC cycles. Requests during the wait and the guard are ignored, and a pin that the block itself held low is never taken as a new request.
- R10: If the pins are not sensed high within WAIT_TO cycles of entering the wait, `stuck_err_o` rises and the block keeps waiting. The flag stays set until the next power-on reset.
- R11: `status_o` encodes 0 idle, 1 power-on, 2 hard, 3 soft, 4 wait-or-guard.
- R12: When hard and soft requests are seen in idle in the same cycle, the hard flow wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| pll_locked_i | input | 1 | PLL lock indication |
| hard_req_i | input | 1 | Internal hard reset request |
| soft_req_i | input | 1 | Internal soft reset request |
| hard_pin_i | input | 1 | Sensed level of the hard-reset pad |
| soft_pin_i | input | 1 | Sensed level of the soft-reset pad |
| hard_drv_o | output | 1 | 1 pulls the hard-reset pad low |
| soft_drv_o | output | 1 | 1 pulls the soft-reset pad low |
| int_rst_n_o | output | 1 | Internal power-on reset, active low |
| cfg_sample_o | output | 1 | Mode-pin capture strobe |
| cfg_load_o | output | 1 | Hard configuration load strobe |
| status_o | output | 3 | Active flow code |
| stuck_err_o | output | 1 | Sticky pin-stuck-low flag |

## Verification
The bench sweeps the moment a hard request hits a running soft flow across every soft cycle, including the last one. A sequencer that let the soft counter finish first would show a short or missing hard pulse there. It also drops a soft request into every cycle of a hard flow and a hard request into every wait and guard cycle. A design that latched either request would show an extra pulse after the guard. The three power-on hold lengths are checked against separate counts, which catches a shared counter or a count that starts at power-on release instead of at lock. A hard pad held low past the timeout must set the flag after exactly WAIT_TO cycles, and the flag must survive the return to idle but not the next power-on.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR_HOLD,
        ST_POR_LOCK,
        ST_POR_EXT,
        ST_IDLE,
        ST_HARD,
        ST_SOFT,
        ST_WAIT,
        ST_GUARD
    } seq_state_e;

    typedef enum logic [2:0] {
        STAT_IDLE   = 3'd0,
        STAT_POWER  = 3'd1,
        STAT_HARD   = 3'd2,
        STAT_SOFT   = 3'd3,
        STAT_SETTLE = 3'd4
    } seq_status_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rst_stuck_mon.sv
module rst_stuck_mon #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic waiting_i,
    output logic err_o
);

    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);
    localparam logic [W-1:0] TOP  = W'(LIMIT);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         err;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (!waiting_i)          mon_d.cnt = '0;
        else if (mon_q.cnt != TOP) mon_d.cnt = mon_q.cnt + 1'b1;
        if (waiting_i && mon_q.cnt == LAST) mon_d.err = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mon_q <= '0;
        else         mon_q <= mon_d;
    end

    assign err_o = mon_q.err;

    // R10
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // R10
    err_rise_in_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> $past(waiting_i));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned HARD_CYC     = 1024,
    parameter int unsigned SOFT_CYC     = 512,
    parameter int unsigned POR_HARD_CYC = 512,
    parameter int unsigned POR_SOFT_CYC = 515,
    parameter int unsigned POR_INT_CYC  = 1024,
    parameter int unsigned GUARD_CYC    = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pll_locked_i,
    input  logic       hard_req_i,
    input  logic       soft_req_i,
    input  logic       hard_pin_s_i,
    input  logic       soft_pin_s_i,
    output logic       hard_drv_o,
    output logic       soft_drv_o,
    output logic       int_rst_n_o,
    output logic       cfg_sample_o,
    output logic       cfg_load_o,
    output logic       waiting_o,
    output logic [2:0] status_o
);

    localparam int unsigned POR_MAX = umax(umax(POR_HARD_CYC, POR_SOFT_CYC), POR_INT_CYC);
    localparam int unsigned CNT_MAX = umax(umax(POR_MAX, GUARD_CYC), umax(HARD_CYC, SOFT_CYC));
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_MAX - 1);
    localparam logic [CNT_W-1:0] HARD_LAST  = CNT_W'(HARD_CYC - 1);
    localparam logic [CNT_W-1:0] SOFT_LAST  = CNT_W'(SOFT_CYC - 1);
    localparam logic [CNT_W-1:0] GUARD_LAST = CNT_W'(GUARD_CYC - 1);
    localparam logic [CNT_W-1:0] PH_LEN     = CNT_W'(POR_HARD_CYC);
    localparam logic [CNT_W-1:0] PS_LEN     = CNT_W'(POR_SOFT_CYC);
    localparam logic [CNT_W-1:0] PI_LEN     = CNT_W'(POR_INT_CYC);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             smp;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic hard_any, soft_any;
    assign hard_any = hard_req_i | ~hard_pin_s_i;
    assign soft_any = soft_req_i | ~soft_pin_s_i;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.smp = 1'b0;
        fsm_d.cnt = fsm_q.cnt + 1'b1;
        unique case (fsm_q.st)
            ST_POR_HOLD: begin
                fsm_d.st  = ST_POR_LOCK;
                fsm_d.smp = 1'b1;
                fsm_d.cnt = '0;
            end
            ST_POR_LOCK: begin
                fsm_d.cnt = '0;
                if (pll_locked_i) fsm_d.st = ST_POR_EXT;
            end
            ST_POR_EXT: begin
                if (fsm_q.cnt == POR_LAST) begin
                    fsm_d.st  = ST_WAIT;
                    fsm_d.cnt = '0;
                end
            end
            ST_IDLE: begin
                fsm_d.cnt = '0;
                if (hard_any)      fsm_d.st = ST_HARD;
                else if (soft_any) fsm_d.st = ST_SOFT;
            end
            ST_HARD: begin
                if (fsm_q.cnt == HARD_LAST) begin
                    fsm_d.st  = ST_WAIT;
                    fsm_d.cnt = '0;
                end
            end
            ST_SOFT: begin
                if (hard_any) begin
                    fsm_d.st  = ST_HARD;
                    fsm_d.cnt = '0;
                end else if (fsm_q.cnt == SOFT_LAST) begin
                    fsm_d.st  = ST_WAIT;
                    fsm_d.cnt = '0;
                end
            end
            ST_WAIT: begin
                fsm_d.cnt = '0;
                if (hard_pin_s_i && soft_pin_s_i) fsm_d.st = ST_GUARD;
            end
            ST_GUARD: begin
                if (fsm_q.cnt == GUARD_LAST) begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.cnt = '0;
                end
            end
            default: begin
                fsm_d.st  = ST_POR_HOLD;
                fsm_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.st  <= ST_POR_HOLD;
            fsm_q.cnt <= '0;
            fsm_q.smp <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    logic in_por_early, in_por_ext;
    assign in_por_early = (fsm_q.st == ST_POR_HOLD) || (fsm_q.st == ST_POR_LOCK);
    assign in_por_ext   = (fsm_q.st == ST_POR_EXT);

    always_comb begin
        hard_drv_o   = in_por_early || (fsm_q.st == ST_HARD)
                       || (in_por_ext && fsm_q.cnt < PH_LEN);
        soft_drv_o   = in_por_early || (fsm_q.st == ST_HARD) || (fsm_q.st == ST_SOFT)
                       || (in_por_ext && fsm_q.cnt < PS_LEN);
        int_rst_n_o  = !(in_por_early || (in_por_ext && fsm_q.cnt < PI_LEN));
        cfg_load_o   = (fsm_q.st == ST_HARD) && (fsm_q.cnt == '0);
        cfg_sample_o = fsm_q.smp;
        waiting_o    = (fsm_q.st == ST_WAIT);
        unique case (fsm_q.st)
            ST_IDLE:           status_o = STAT_IDLE;
            ST_HARD:           status_o = STAT_HARD;
            ST_SOFT:           status_o = STAT_SOFT;
            ST_WAIT, ST_GUARD: status_o = STAT_SETTLE;
            default:           status_o = STAT_POWER;
        endcase
    end

    // Checker-only run-length counter of consecutive hard-flow cycles.
    logic [CNT_W:0] hard_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    hard_run_q <= '0;
        else if (status_o != STAT_HARD) hard_run_q <= '0;
        else                            hard_run_q <= hard_run_q + 1'b1;
    end

    // R4
    hard_drags_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hard_drv_o |-> soft_drv_o);

    // R4
    hard_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hard_run_q <= (CNT_W+1)'(HARD_CYC));

    // R5
    cfg_load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_load_o |=> !cfg_load_o);

    // R5
    hard_rise_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(hard_drv_o) && status_o == STAT_HARD) |-> cfg_load_o);

    // R2
    sample_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_sample_o |=> !cfg_sample_o);

    // R7
    preempt_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == STAT_SOFT && hard_req_i) |=> status_o == STAT_HARD);

    // R12
    idle_hard_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == STAT_IDLE && hard_req_i) |=> status_o == STAT_HARD);

    // R9
    settle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == STAT_SETTLE && int_rst_n_o) |-> !hard_drv_o && !soft_drv_o);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
    parameter int unsigned HARD_CYC     = 1024,
    parameter int unsigned SOFT_CYC     = 512,
    parameter int unsigned POR_HARD_CYC = 512,
    parameter int unsigned POR_SOFT_CYC = 515,
    parameter int unsigned POR_INT_CYC  = 1024,
    parameter int unsigned GUARD_CYC    = 16,
    parameter int unsigned WAIT_TO      = 4096,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       pll_locked_i,
    input  logic       hard_req_i,
    input  logic       soft_req_i,
    input  logic       hard_pin_i,
    input  logic       soft_pin_i,
    output logic       hard_drv_o,
    output logic       soft_drv_o,
    output logic       int_rst_n_o,
    output logic       cfg_sample_o,
    output logic       cfg_load_o,
    output logic [2:0] status_o,
    output logic       stuck_err_o
);

    logic [1:0] pins_s;
    logic       waiting;

    rst_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (por_n_i),
        .async_i ({hard_pin_i, soft_pin_i}),
        .sync_o  (pins_s)
    );

    rst_seq_fsm #(
        .HARD_CYC     (HARD_CYC),
        .SOFT_CYC     (SOFT_CYC),
        .POR_HARD_CYC (POR_HARD_CYC),
        .POR_SOFT_CYC (POR_SOFT_CYC),
        .POR_INT_CYC  (POR_INT_CYC),
        .GUARD_CYC    (GUARD_CYC)
    ) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (por_n_i),
        .pll_locked_i (pll_locked_i),
        .hard_req_i   (hard_req_i),
        .soft_req_i   (soft_req_i),
        .hard_pin_s_i (pins_s[1]),
        .soft_pin_s_i (pins_s[0]),
        .hard_drv_o   (hard_drv_o),
        .soft_drv_o   (soft_drv_o),
        .int_rst_n_o  (int_rst_n_o),
        .cfg_sample_o (cfg_sample_o),
        .cfg_load_o   (cfg_load_o),
        .waiting_o    (waiting),
        .status_o     (status_o)
    );

    rst_stuck_mon #(.LIMIT(WAIT_TO)) u_mon (
        .clk_i     (clk_i),
        .rst_ni    (por_n_i),
        .waiting_i (waiting),
        .err_o     (stuck_err_o)
    );

    // R1
    por_holds_chk: assert property (@(posedge clk_i)
        !por_n_i |-> hard_drv_o && soft_drv_o && !int_rst_n_o && !stuck_err_o);

endmodule

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;

    localparam int HC = 10, SC = 7, PH = 6, PS = 9, PI = 12, GC = 5, TO = 20;
    localparam int SETTLE = 3 + GC;   // pin-high wait through synchronizer plus guard
    localparam int WIN = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic por_n = 1'b0, pll = 1'b0, hreq = 1'b0, sreq = 1'b0;
    logic ext_h = 1'b0, ext_s = 1'b0, stuck_h = 1'b0;
    logic hard_drv, soft_drv, int_rst_n, smp, ld, err;
    logic [2:0] st;
    logic hard_pin, soft_pin;

    assign hard_pin = ~(hard_drv | ext_h | stuck_h);
    assign soft_pin = ~(soft_drv | ext_s);

    rst_seq_ctrl #(
        .HARD_CYC(HC), .SOFT_CYC(SC), .POR_HARD_CYC(PH), .POR_SOFT_CYC(PS),
        .POR_INT_CYC(PI), .GUARD_CYC(GC), .WAIT_TO(TO), .SYNC_STAGES(2)
    ) u0 (
        .clk_i(clk), .por_n_i(por_n), .pll_locked_i(pll), .hard_req_i(hreq),
        .soft_req_i(sreq), .hard_pin_i(hard_pin), .soft_pin_i(soft_pin),
        .hard_drv_o(hard_drv), .soft_drv_o(soft_drv), .int_rst_n_o(int_rst_n),
        .cfg_sample_o(smp), .cfg_load_o(ld), .status_o(st), .stuck_err_o(err)
    );

    int n_chk = 0, n_fail = 0;
    int c_h, c_s, c_i, c_l, c_smp, c_st2, c_st3, c_st4;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // kind: 0 none, 1 hard request after sample inj_at, 2 soft request after sample inj_at,
    //       3 hard request in the inj_at-th settle cycle
    task automatic observe(input int win, input int clr, input int inj_at, input int kind);
        int settle_seen = 0;
        bit pend = 0;
        c_h = 0; c_s = 0; c_i = 0; c_l = 0; c_smp = 0; c_st2 = 0; c_st3 = 0; c_st4 = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (i == clr) begin hreq = 0; sreq = 0; ext_h = 0; ext_s = 0; end
            if (pend) begin hreq = 0; sreq = 0; ext_s = 0; pend = 0; end
            c_h   += int'(hard_drv);
            c_s   += int'(soft_drv);
            c_i   += int'(!int_rst_n);
            c_l   += int'(ld);
            c_smp += int'(smp);
            c_st2 += int'(st == 3'd2);
            c_st3 += int'(st == 3'd3);
            if (st == 3'd4) begin
                c_st4++;
                if (kind == 3 && settle_seen == inj_at) begin hreq = 1; pend = 1; end
                settle_seen++;
            end
            if (kind == 1 && i == inj_at) begin hreq = 1; pend = 1; end
            if (kind == 2 && i == inj_at) begin sreq = 1; ext_s = 1; pend = 1; end
        end
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (st != 3'd0 && k < 80) begin @(negedge clk); k++; end
        check(req, "return to idle status", int'(st), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e;
        repeat (20) @(negedge clk);
        // R1 reset state
        check("R1", "hard drive in reset", int'(hard_drv), 1);
        check("R1", "soft drive in reset", int'(soft_drv), 1);
        check("R1", "int reset in reset", int'(int_rst_n), 0);
        check("R1", "status in reset", int'(st), 1);
        check("R1", "stuck flag in reset", int'(err), 0);
        check("R1", "sample strobe in reset", int'(smp), 0);

        // R2 / R3: release power-on without lock
        por_n = 1;
        observe(15, -1, -1, 0);
        check("R2", "mode sample strobes", c_smp, 1);
        check("R3", "hard held without lock", c_h, 15);
        check("R3", "soft held without lock", c_s, 15);
        check("R3", "int reset held without lock", c_i, 15);
        check("R11", "power-on status", int'(st), 1);

        // R3 lock-relative extensions
        pll = 1;
        observe(PI + 4, -1, -1, 0);
        check("R3", "hard extension after lock", c_h, PH);
        check("R3", "soft extension after lock", c_s, PS);
        check("R3", "int reset extension after lock", c_i, PI);
        wait_idle("R3");
        check("R11", "idle drivers quiet", int'(hard_drv | soft_drv), 0);

        // R4 R6 R12 R9 R11: every request source
        for (int src = 0; src < 5; src++) begin
            @(negedge clk);
            case (src)
                0: ext_h = 1;
                1: hreq = 1;
                2: ext_s = 1;
                3: sreq = 1;
                default: begin hreq = 1; sreq = 1; end
            endcase
            observe(WIN, (src == 0 || src == 2) ? 2 : 0, -1, 0);
            if (src == 0 || src == 1 || src == 4) begin
                check("R4", $sformatf("hard drive len src%0d", src), c_h, HC);
                check("R4", $sformatf("soft dragged len src%0d", src), c_s, HC);
                check("R5", $sformatf("config load strobes src%0d", src), c_l, 1);
                check("R11", $sformatf("hard status cycles src%0d", src), c_st2, HC);
                if (src == 4) check("R12", "hard wins over soft", c_st3, 0);
            end else begin
                check("R6", $sformatf("soft drive len src%0d", src), c_s, SC);
                check("R6", $sformatf("no hard drive src%0d", src), c_h, 0);
                check("R5", $sformatf("no load in soft src%0d", src), c_l, 0);
                check("R11", $sformatf("soft status cycles src%0d", src), c_st3, SC);
            end
            check("R9", $sformatf("settle cycles src%0d", src), c_st4, SETTLE);
            wait_idle("R9");
        end

        // R7 preemption at every soft cycle
        for (int k = 1; k <= SC; k++) begin
            @(negedge clk); sreq = 1;
            observe(WIN, 0, k - 1, 1);
            check("R7", $sformatf("hard len preempt k%0d", k), c_h, HC);
            check("R7", $sformatf("soft total preempt k%0d", k), c_s, k + HC);
            check("R7", $sformatf("load strobe preempt k%0d", k), c_l, 1);
            wait_idle("R7");
        end

        // R8 soft request at every hard cycle
        for (int j = 0; j < HC; j++) begin
            @(negedge clk); hreq = 1;
            observe(WIN, 0, j, 2);
            check("R8", $sformatf("hard len with soft at %0d", j), c_h, HC);
            check("R8", $sformatf("soft len with soft at %0d", j), c_s, HC);
            check("R8", $sformatf("no soft status at %0d", j), c_st3, 0);
            wait_idle("R8");
        end

        // R9 hard request in every settle cycle
        for (int j = 0; j < SETTLE; j++) begin
            @(negedge clk); hreq = 1;
            observe(WIN, 0, j, 3);
            check("R9", $sformatf("single hard flow, request in settle %0d", j), c_h, HC);
            check("R9", $sformatf("single load, request in settle %0d", j), c_l, 1);
            wait_idle("R9");
        end

        // R10 stuck-low pad
        @(negedge clk); hreq = 1; stuck_h = 1;
        @(negedge clk); hreq = 0;
        e = 0;
        while (st != 3'd4 && e < 40) begin @(negedge clk); e++; end
        e = 0;
        while (!err && e < 100) begin
            if (st == 3'd4) e++;
            @(negedge clk);
        end
        check("R10", "cycles waited before flag", e, TO);
        repeat (10) @(negedge clk);
        check("R10", "still waiting after timeout", int'(st), 4);
        check("R10", "drivers released while stuck", int'(hard_drv | soft_drv), 0);
        stuck_h = 0;
        wait_idle("R10");
        check("R10", "flag sticky in idle", int'(err), 1);

        // R1 R10 second power-on clears flag
        por_n = 0;
        @(negedge clk);
        check("R1", "flag cleared by power-on", int'(err), 0);
        check("R1", "drivers asserted on power-on", int'(hard_drv & soft_drv), 1);
        repeat (16) @(negedge clk);
        por_n = 1;
        observe(PI + 6, -1, -1, 0);
        check("R2", "sample strobe second power-on", c_smp, 1);
        wait_idle("R10");
        check("R10", "flag stays clear", int'(err), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule